// File: doc/BRIEF.md
# Hibernation Power Sequencing Controller

This controller sits in the always-powered domain and decides when the main regulator of the processor domain is switched off and when it is switched back on. Software asks for hibernation by pulsing a request. The controller then waits a programmable settling interval and drops the regulator enable. It raises the enable again when an enabled wake source fires, and after a second programmable interval it is back in its running state. A low-battery comparator input can veto the request when the abort mode is selected.

Four event sources are recorded in a sticky raw status field: pin wake, low battery, RTC match 0 and RTC match 1. Each bit is cleared by writing one to it, and a mask gates the bits onto a single interrupt line. After power returns, software reads the raw status to learn why it woke up. It reads the active flag to tell a wake from a cold start. These control and status pins are plain signals with no handshake.

Top module: `hib_pwr_ctrl`

## Requirements
- R1: `pwr_state_o` encodes RUN=0, POWER_DOWN_PENDING=1, HIBERNATING=2, WAKING=3. `reg_en_o` is low in HIBERNATING only. The enable falls only on the step from POWER_DOWN_PENDING and rises only on the step into WAKING.
- R2: A request bit held in RUN without an abort moves the controller to POWER_DOWN_PENDING on the next edge. It stays there for PD_CYCLES cycles and then enters HIBERNATING.
- R3: A `hib_req_set_i` pulse in RUN sets `hib_req_o` at the next edge. `hib_req_o` is cleared on the edge that returns the controller from WAKING to RUN.
- R4: With `lowbat_abort_i`=1, a synchronised low battery while the request is pending in RUN or POWER_DOWN_PENDING clears `hib_req_o` and leaves the controller in RUN. With `lowbat_abort_i`=0 the request proceeds to HIBERNATING even with a low battery.
- R5: In HIBERNATING, the wake pin (active low, through a two-flop synchroniser) wakes the controller when `wake_pin_en_i`=1. A one-cycle match pulse on either RTC input wakes it when `wake_rtc_en_i`=1. A source whose enable is 0 has no effect. WAKING lasts WAKE_CYCLES cycles and then returns to RUN.
- R6: The raw status bits are: bit 0 pin wake, set when the pin wakes the controller out of HIBERNATING; bit 1 low battery, set while the synchronised comparator input is high; bit 2 RTC match 0; bit 3 RTC match 1. The bits are sticky and are set whatever the mask holds.
- R7: A one in `irq_clr_i` clears that raw bit at the next edge. If the bit's event is present in the same cycle, the set wins.
- R8: `masked_status_o` is raw AND `irq_mask_i`. `irq_o` is high when any masked bit is high.
- R9: `active_o` follows `mod_en_i` one edge later and is unaffected by hibernation cycles.
- R10: After reset the controller is in RUN with `reg_en_o`=1, and the request, raw status and active flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en_i | input | 1 | Module clock enable setting |
| hib_req_set_i | input | 1 | One-cycle pulse requesting hibernation |
| lowbat_abort_i | input | 1 | 1: low battery aborts a request; 0: detect only |
| lowbat_raw_i | input | 1 | Low-battery comparator output, asynchronous |
| wake_pin_en_i | input | 1 | Enable wake from the pin |
| wake_rtc_en_i | input | 1 | Enable wake from RTC matches |
| wake_pin_n_i | input | 1 | Wake pin, active low, asynchronous |
| rtc_match0_i | input | 1 | RTC match 0 pulse |
| rtc_match1_i | input | 1 | RTC match 1 pulse |
| irq_mask_i | input | 4 | Interrupt mask |
| irq_clr_i | input | 4 | Write-one-to-clear strobe for the raw status |
| reg_en_o | output | 1 | Regulator enable for the processor domain |
| pwr_state_o | output | 2 | Controller state |
| hib_req_o | output | 1 | Pending hibernate request bit |
| active_o | output | 1 | Active flag |
| raw_status_o | output | 4 | Raw event status |
| masked_status_o | output | 4 | Masked event status |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume the following about the inputs. RTC match and clear strobes are synchronous to `clk` and last one cycle. The request pulse is synchronous. The only inputs treated as asynchronous are the pin and the comparator, and both pass through the synchronisers before they are used. The stimulus drives every input on the falling edge and pulses the match, request and clear lines for exactly one cycle. It changes the pin and comparator levels freely. A behavioural model, fed the same inputs, predicts every output on every cycle.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_HIB  = 2'd2,
    ST_WAKE = 2'd3
  } pwr_state_e;

  localparam int unsigned N_EVT     = 4;
  localparam int unsigned EVT_PIN   = 0;
  localparam int unsigned EVT_LOBAT = 1;
  localparam int unsigned EVT_M0    = 2;
  localparam int unsigned EVT_M1    = 3;
endpackage

// File: rtl/hib_sync.sv
module hib_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hib_seq_fsm.sv
module hib_seq_fsm
  import hib_pkg::*;
#(
  parameter int unsigned PD_CYCLES = 4,
  parameter int unsigned WAKE_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_set_i,
  input  logic       abort_mode_i,
  input  logic       lowbat_i,
  input  logic       pin_en_i,
  input  logic       pin_act_i,
  input  logic       rtc_en_i,
  input  logic       match0_i,
  input  logic       match1_i,
  output pwr_state_e state_o,
  output logic       req_o,
  output logic       pin_wake_o
);
  localparam int unsigned MAXC = (PD_CYCLES > WAKE_CYCLES) ? PD_CYCLES : WAKE_CYCLES;
  localparam int unsigned CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] PD_LOAD = CW'(PD_CYCLES - 1);
  localparam logic [CW-1:0] WK_LOAD = CW'(WAKE_CYCLES - 1);

  pwr_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic req_q, req_d;
  logic abort, wake;

  assign abort = abort_mode_i & lowbat_i;
  assign wake  = (pin_en_i & pin_act_i) | (rtc_en_i & (match0_i | match1_i));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    req_d = req_q | (req_set_i & (st_q == ST_RUN));
    case (st_q)
      ST_RUN: begin
        if (req_q) begin
          if (abort) begin
            req_d = 1'b0;
          end else begin
            st_d  = ST_PEND;
            cnt_d = PD_LOAD;
          end
        end
      end
      ST_PEND: begin
        if (abort) begin
          st_d  = ST_RUN;
          req_d = 1'b0;
        end else if (cnt_q == '0) begin
          st_d = ST_HIB;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HIB: begin
        if (wake) begin
          st_d  = ST_WAKE;
          cnt_d = WK_LOAD;
        end
      end
      ST_WAKE: begin
        if (cnt_q == '0) begin
          st_d  = ST_RUN;
          req_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign state_o    = st_q;
  assign req_o      = req_q;
  assign pin_wake_o = (st_q == ST_HIB) & pin_en_i & pin_act_i;
endmodule

// File: rtl/hib_irq_stat.sv
module hib_irq_stat
  import hib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] set_i,
  input  logic [N_EVT-1:0] clr_i,
  input  logic [N_EVT-1:0] mask_i,
  output logic [N_EVT-1:0] raw_o,
  output logic [N_EVT-1:0] masked_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] raw_q;

  for (genvar b = 0; b < N_EVT; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        raw_q[b] <= 1'b0;
      else if (set_i[b]) raw_q[b] <= 1'b1;
      else if (clr_i[b]) raw_q[b] <= 1'b0;
    end
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/hib_pwr_ctrl.sv
module hib_pwr_ctrl
  import hib_pkg::*;
#(
  parameter int unsigned PD_CYCLES = 4,
  parameter int unsigned WAKE_CYCLES = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mod_en_i,
  input  logic       hib_req_set_i,
  input  logic       lowbat_abort_i,
  input  logic       lowbat_raw_i,
  input  logic       wake_pin_en_i,
  input  logic       wake_rtc_en_i,
  input  logic       wake_pin_n_i,
  input  logic       rtc_match0_i,
  input  logic       rtc_match1_i,
  input  logic [3:0] irq_mask_i,
  input  logic [3:0] irq_clr_i,
  output logic       reg_en_o,
  output logic [1:0] pwr_state_o,
  output logic       hib_req_o,
  output logic       active_o,
  output logic [3:0] raw_status_o,
  output logic [3:0] masked_status_o,
  output logic       irq_o
);
  logic [1:0] sync_q;
  logic       pin_act, lb_sync, pin_wake, active_q;
  pwr_state_e state;
  logic [N_EVT-1:0] evt_set;

  // bit 1: wake pin (idles high), bit 0: comparator (idles low)
  hib_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({wake_pin_n_i, lowbat_raw_i}),
    .q_o   (sync_q)
  );

  assign pin_act = ~sync_q[1];
  assign lb_sync = sync_q[0];

  hib_seq_fsm #(.PD_CYCLES(PD_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_set_i    (hib_req_set_i),
    .abort_mode_i (lowbat_abort_i),
    .lowbat_i     (lb_sync),
    .pin_en_i     (wake_pin_en_i),
    .pin_act_i    (pin_act),
    .rtc_en_i     (wake_rtc_en_i),
    .match0_i     (rtc_match0_i),
    .match1_i     (rtc_match1_i),
    .state_o      (state),
    .req_o        (hib_req_o),
    .pin_wake_o   (pin_wake)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EVT_PIN]   = pin_wake;
    evt_set[EVT_LOBAT] = lb_sync;
    evt_set[EVT_M0]    = rtc_match0_i;
    evt_set[EVT_M1]    = rtc_match1_i;
  end

  hib_irq_stat u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_set),
    .clr_i    (irq_clr_i),
    .mask_i   (irq_mask_i),
    .raw_o    (raw_status_o),
    .masked_o (masked_status_o),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= mod_en_i;
  end

  assign active_o    = active_q;
  assign pwr_state_o = state;
  assign reg_en_o    = (state != ST_HIB);
endmodule

// File: rtl/hib_pwr_ctrl_chk.sv
module hib_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_en_o,
  input logic [1:0] pwr_state_o,
  input logic       hib_req_o,
  input logic       lowbat_abort_i,
  input logic       lb_sync,
  input logic       wake_pin_en_i,
  input logic       wake_rtc_en_i,
  input logic [3:0] raw_status_o,
  input logic [3:0] irq_clr_i
);
  a_r1_enable_falls_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_en_o) |-> $past(pwr_state_o) == 2'd1);

  a_r1_enable_rises_into_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en_o) |-> pwr_state_o == 2'd3);

  a_r3_req_cleared_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd3 && $past(pwr_state_o) == 2'd3 && hib_req_o) |=>
      (pwr_state_o == 2'd3 || !hib_req_o));

  a_r4_abort_keeps_run: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd0 && hib_req_o && lowbat_abort_i && lb_sync) |=>
      (pwr_state_o == 2'd0 && !hib_req_o));

  a_r5_no_wake_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state_o == 2'd2 && !wake_pin_en_i && !wake_rtc_en_i) |=> pwr_state_o == 2'd2);

  for (genvar b = 0; b < 4; b++) begin : g_sticky
    a_r6_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_status_o[b] && !irq_clr_i[b]) |=> raw_status_o[b]);
  end
endmodule

bind hib_pwr_ctrl hib_pwr_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_en_o       (reg_en_o),
  .pwr_state_o    (pwr_state_o),
  .hib_req_o      (hib_req_o),
  .lowbat_abort_i (lowbat_abort_i),
  .lb_sync        (lb_sync),
  .wake_pin_en_i  (wake_pin_en_i),
  .wake_rtc_en_i  (wake_rtc_en_i),
  .raw_status_o   (raw_status_o),
  .irq_clr_i      (irq_clr_i)
);

// File: tb/test_hib_pwr_ctrl.sv
`timescale 1ns/1ps
module test_hib_pwr_ctrl;
  localparam int PD = 4;
  localparam int WK = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 0, req_set = 0, ab_mode = 0, lb_in = 0, pin_en = 0, rtc_en = 0;
  logic pin_n = 1, m0 = 0, m1 = 0;
  logic [3:0] mask = 0, clr = 0;
  logic reg_en, req, act, irq;
  logic [1:0] st;
  logic [3:0] raw, msk;

  always #2.5 clk = ~clk;

  hib_pwr_ctrl #(.PD_CYCLES(PD), .WAKE_CYCLES(WK), .SYNC_STAGES(2)) i_hib_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .mod_en_i(mod_en), .hib_req_set_i(req_set),
    .lowbat_abort_i(ab_mode), .lowbat_raw_i(lb_in), .wake_pin_en_i(pin_en),
    .wake_rtc_en_i(rtc_en), .wake_pin_n_i(pin_n), .rtc_match0_i(m0), .rtc_match1_i(m1),
    .irq_mask_i(mask), .irq_clr_i(clr), .reg_en_o(reg_en), .pwr_state_o(st),
    .hib_req_o(req), .active_o(act), .raw_status_o(raw), .masked_status_o(msk), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic check(input string tag, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Behavioural reference model: 0 RUN, 1 PEND, 2 HIB, 3 WAKE
  int s_st, s_cnt, s_req, s_act;
  int s_raw;
  int p1, p2, l1, l2;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_st = 0; s_cnt = 0; s_req = 0; s_act = 0; s_raw = 0;
      p1 = 1; p2 = 1; l1 = 0; l2 = 0;
    end else begin
      int n_st, n_cnt, n_req, setv;
      bit pin_act, lb, abort;
      pin_act = (p2 == 0);
      lb = (l2 != 0);
      abort = ab_mode && lb;
      n_st = s_st; n_cnt = s_cnt;
      n_req = (s_req != 0 || (req_set && s_st == 0)) ? 1 : 0;
      setv = 0;
      if (s_st == 2 && pin_en && pin_act) setv += 1;
      if (lb) setv += 2;
      if (m0) setv += 4;
      if (m1) setv += 8;
      if (s_st == 0) begin
        if (s_req != 0) begin
          if (abort) n_req = 0;
          else begin n_st = 1; n_cnt = PD - 1; end
        end
      end else if (s_st == 1) begin
        if (abort) begin n_st = 0; n_req = 0; end
        else if (s_cnt == 0) n_st = 2;
        else n_cnt = s_cnt - 1;
      end else if (s_st == 2) begin
        if ((pin_en && pin_act) || (rtc_en && (m0 || m1))) begin n_st = 3; n_cnt = WK - 1; end
      end else begin
        if (s_cnt == 0) begin n_st = 0; n_req = 0; end
        else n_cnt = s_cnt - 1;
      end
      s_raw = (s_raw & ~int'(clr)) | setv;
      s_st = n_st; s_cnt = n_cnt; s_req = n_req;
      p2 = p1; p1 = int'(pin_n);
      l2 = l1; l1 = int'(lb_in);
      s_act = int'(mod_en);
    end
  end

  always @(posedge clk) begin
    #2;
    if (cmp_on && rst_n) begin
      check("R1 reg_en", int'(reg_en), (s_st == 2) ? 0 : 1);
      check("R2 state", int'(st), s_st);
      check("R3 req", int'(req), s_req);
      check("R6 raw", int'(raw), s_raw);
      check("R8 masked", int'(msk), s_raw & int'(mask));
      check("R8 irq", int'(irq), ((s_raw & int'(mask)) != 0) ? 1 : 0);
      check("R9 active", int'(act), s_act);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    req_set = 1; tick(1); req_set = 0;
  endtask

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R10 actual=timeout expected=done");
      finish_sim();
    end
  end

  initial begin
    tick(4);
    rst_n = 1;
    tick(1);
    cmp_on = 1;
    check("R10 reset state", int'(st), 0);
    check("R10 reset reg_en", int'(reg_en), 1);
    check("R10 reset raw", int'(raw), 0);
    check("R10 reset req/active", int'(req) + int'(act), 0);

    mod_en = 1; tick(2);
    check("R9 active follows enable", int'(act), 1);

    // R2: detect-only, battery fine -> hibernate
    pulse_req();
    check("R3 request latched", int'(req), 1);
    tick(1);
    check("R2 pending after request", int'(st), 1);
    tick(PD);
    check("R2 hibernating after delay", int'(st), 2);
    check("R1 regulator off", int'(reg_en), 0);

    // R5: disabled pin does nothing
    pin_n = 0; tick(6);
    check("R5 disabled pin ignored", int'(st), 2);
    pin_n = 1; tick(3);
    m1 = 1; tick(1); m1 = 0; tick(1);
    check("R5 disabled rtc ignored", int'(st), 2);
    check("R6 match1 recorded", int'(raw[3]), 1);

    rtc_en = 1; m0 = 1; tick(1); m0 = 0;
    check("R5 rtc wake", int'(st), 3);
    check("R1 regulator on while waking", int'(reg_en), 1);
    tick(WK);
    check("R5 back in run", int'(st), 0);
    check("R3 request cleared on return", int'(req), 0);
    check("R9 active survives", int'(act), 1);

    // R7/R8 masking and clear
    mask = 4'b0100; tick(1);
    check("R8 irq from match0", int'(irq), 1);
    clr = 4'b1100; tick(1); clr = 0;
    check("R7 cleared", int'(raw), 0);
    check("R8 irq drops", int'(irq), 0);

    // R4: abort mode with low battery in RUN
    ab_mode = 1; lb_in = 1; tick(3);
    pulse_req(); tick(2);
    check("R4 abort in run state", int'(st), 0);
    check("R4 abort clears request", int'(req), 0);
    check("R6 low battery raw", int'(raw[1]), 1);
    clr = 4'b0010; tick(1); clr = 0;
    check("R7 set wins over clear", int'(raw[1]), 1);

    // R4: abort during pending
    lb_in = 0; tick(4);
    clr = 4'b0010; tick(1); clr = 0;
    check("R7 low battery cleared", int'(raw[1]), 0);
    pulse_req(); tick(1);
    check("R2 pending again", int'(st), 1);
    lb_in = 1; tick(3);
    check("R4 abort from pending", int'(st), 0);
    check("R4 request dropped", int'(req), 0);

    // R4: detect-only proceeds despite low battery
    ab_mode = 0; tick(1);
    pulse_req(); tick(PD + 2);
    check("R4 detect-only hibernates", int'(st), 2);
    lb_in = 0;

    // R5/R6: wake by pin
    rtc_en = 0; pin_en = 1; mask = 4'b0001;
    pin_n = 0; tick(3);
    check("R5 pin wake", int'(st), 3);
    check("R6 pin wake recorded", int'(raw[0]), 1);
    check("R8 irq from pin", int'(irq), 1);
    pin_n = 1; tick(WK + 1);
    check("R5 run after pin wake", int'(st), 0);

    // R6: pin low in RUN does not set pin bit
    clr = 4'b1111; tick(1); clr = 0;
    pin_n = 0; tick(4); pin_n = 1; tick(3);
    check("R6 pin in run not recorded", int'(raw[0]), 0);

    // R6: match in RUN recorded regardless of mask, no state change
    mask = 0; m1 = 1; tick(1); m1 = 0;
    check("R6 match1 in run", int'(raw[3]), 1);
    check("R8 masked off", int'(irq), 0);
    check("R2 state unchanged", int'(st), 0);

    mod_en = 0; tick(2);
    check("R9 active clears", int'(act), 0);

    tick(2);
    done = 1;
    finish_sim();
  end
endmodule